// File: doc/BRIEF.md
# Wi-Fi/Bluetooth Coexistence Arbiter

This block sits on the WLAN side of a packet-traffic coexistence link to a Bluetooth radio on the same board. The Bluetooth side raises a request line for each slot in which it wants the shared 2.4 GHz medium. In three-line mode it also drives a priority line. The arbiter answers on an activity line: low lets the Bluetooth slot go ahead, high blocks it. Each answer is made once, from the WLAN transmit/receive busy state and the WLAN traffic priority, when the request first rises. It then stays fixed until the request drops.

An antenna-select output shows which radio owns the antenna, and a bypass can force it to a fixed value. All four coexistence functions (request, priority, activity, antenna) reach the outside world through seven general-purpose pads. A 3-bit selector per function picks the pad. A mapping that puts two active functions on one pad is flagged, and the arbiter then drives no pad at all.

Top module: `coex_arbiter`

## Requirements
- R1: The request and priority pad levels pass through a two-stage synchronizer. A request edge at a pad changes the activity and antenna outputs after the third rising clock edge that samples the new level, and no sooner.
- R2: When a request rises while `wlan_busy` is low, the slot is granted: activity reads 0 and the antenna reads 1 (Bluetooth) for the length of the request.
- R3: In two-line mode (`three_wire` = 0), a request that rises while `wlan_busy` is high is denied (activity 1, antenna 0). The priority pad has no effect.
- R4: In three-line mode, a request that rises while `wlan_busy` is high is granted only if the synchronized priority is 1 and `wlan_hi_pri` is 0. Otherwise it is denied.
- R5: The grant or denial is decided once, at the request's rising edge. It holds unchanged while the request stays high, whatever `wlan_busy` and `wlan_hi_pri` do in the meantime.
- R6: When no request is active, activity equals `wlan_busy` and the antenna reads 0 (WLAN).
- R7: While `ant_force_en` is 1, the antenna output equals `ant_force_val` regardless of slot state. Otherwise it reads 1 only during a granted slot.
- R8: Selector value 0 to 6 names the pad, and 7 means unassigned. The activity and antenna functions drive only their own pad, with `pad_oe` = 1 there. Every other pad has `pad_oe` = 0 and `pad_out` = 0. Request and priority are read only from their selected pads. An unassigned request reads as 0.
- R9: `map_conflict` is 1 when two functions in use share a pad number 0 to 6. Request, activity and antenna always count as in use when assigned; priority counts only in three-line mode. While `map_conflict` is 1, all of `pad_oe` is 0.
- R10: Reset clears the synchronizer and the slot state. After reset, no slot is active until a fresh request rise has passed the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| three_wire | input | 1 | 1 selects three-line signalling (priority used), 0 selects two-line |
| wlan_busy | input | 1 | WLAN transmit or receive in progress |
| wlan_hi_pri | input | 1 | Current WLAN traffic is high priority |
| ant_force_en | input | 1 | Bypass the owner-driven antenna select |
| ant_force_val | input | 1 | Antenna level used while bypassed |
| sel_req | input | 3 | Pad index for the request input, 7 = unassigned |
| sel_pri | input | 3 | Pad index for the priority input, 7 = unassigned |
| sel_act | input | 3 | Pad index for the activity output, 7 = unassigned |
| sel_ant | input | 3 | Pad index for the antenna output, 7 = unassigned |
| pad_in | input | 7 | Levels seen on the seven pads |
| pad_out | output | 7 | Levels driven toward the pads |
| pad_oe | output | 7 | Per-pad output enable |
| map_conflict | output | 1 | Two in-use functions share a pad |

## Verification
A wrong decision latch shows at the activity pad three edges after the request edge. Because a decision must hold for the whole slot, a latch that re-evaluates shows up as a toggle partway through the slot, on the first clock after `wlan_busy` moves. A synchronizer of the wrong depth shifts every activity and antenna transition by a cycle, so the output disagrees with the model on the edge of each slot. A bad pad decode or conflict check shows as an enable on the wrong pad in the same cycle the selector changes, since the mux is combinational.

// File: rtl/coex_pkg.sv
package coex_pkg;

  typedef enum logic [1:0] {
    FN_REQ = 2'd0,
    FN_PRI = 2'd1,
    FN_ACT = 2'd2,
    FN_ANT = 2'd3
  } coex_fn_e;

  localparam int FN_COUNT = 4;

  // Bluetooth wins the slot when WLAN is idle, or in three-line mode when
  // the slot is urgent and the WLAN traffic is not.
  function automatic logic coex_bt_wins(input logic busy, input logic wlan_hi,
                                        input logic three, input logic bt_pri);
    return !busy || (three && bt_pri && !wlan_hi);
  endfunction

  // Activity level: during a slot it reflects the latched decision,
  // outside a slot it mirrors WLAN busy.
  function automatic logic coex_act_level(input logic slot, input logic grant,
                                          input logic busy);
    return slot ? !grant : busy;
  endfunction

  function automatic logic coex_ant_level(input logic slot, input logic grant,
                                          input logic force_en, input logic force_val);
    return force_en ? force_val : (slot && grant);
  endfunction

endpackage

// File: rtl/coex_sync.sv
module coex_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/coex_decider.sv
module coex_decider
  import coex_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic pri_s,
  input  logic three_wire,
  input  logic wlan_busy,
  input  logic wlan_hi_pri,
  output logic req_rise,
  output logic slot_active,
  output logic bt_grant
);

  logic req_q;
  logic grant_q;

  assign req_rise = req_s && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      req_q <= req_s;
      if (req_rise) grant_q <= coex_bt_wins(wlan_busy, wlan_hi_pri, three_wire, pri_s);
    end
  end

  assign slot_active = req_q;
  assign bt_grant    = grant_q;

  AST_SLOT_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_active) |-> $past(req_rise)); // R1

  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && !wlan_busy) |=> bt_grant); // R2

  AST_TWO_WIRE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && wlan_busy && !three_wire) |=> !bt_grant); // R3

  AST_PRI_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && wlan_busy && three_wire && pri_s && !wlan_hi_pri) |=> bt_grant); // R4

  AST_WLAN_HI_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && wlan_busy && wlan_hi_pri) |=> !bt_grant); // R4

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && $past(slot_active)) |-> $stable(bt_grant)); // R5

endmodule

// File: rtl/coex_padmux.sv
module coex_padmux
  import coex_pkg::*;
#(
  parameter int NUM_PADS = 7,
  parameter int SEL_W    = 3
) (
  input  logic                three_wire,
  input  logic [SEL_W-1:0]    sel_req,
  input  logic [SEL_W-1:0]    sel_pri,
  input  logic [SEL_W-1:0]    sel_act,
  input  logic [SEL_W-1:0]    sel_ant,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic                act_lvl,
  input  logic                ant_lvl,
  output logic                req_raw,
  output logic                pri_raw,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic                map_conflict
);

  localparam logic [SEL_W-1:0] PAD_LIMIT = SEL_W'(NUM_PADS);

  logic [SEL_W-1:0] fsel   [FN_COUNT];
  logic             fin_use[FN_COUNT];

  always_comb begin
    fsel[FN_REQ] = sel_req;
    fsel[FN_PRI] = sel_pri;
    fsel[FN_ACT] = sel_act;
    fsel[FN_ANT] = sel_ant;
    for (int f = 0; f < FN_COUNT; f++) fin_use[f] = (fsel[f] < PAD_LIMIT);
    fin_use[FN_PRI] = fin_use[FN_PRI] && three_wire;
  end

  // Pairwise check of the in-use selectors.
  always_comb begin
    map_conflict = 1'b0;
    for (int a = 0; a < FN_COUNT; a++) begin
      for (int b = a + 1; b < FN_COUNT; b++) begin
        if (fin_use[a] && fin_use[b] && (fsel[a] == fsel[b])) map_conflict = 1'b1;
      end
    end
  end

  // Input selection: a selector outside the pad range reads as 0.
  always_comb begin
    req_raw = 1'b0;
    pri_raw = 1'b0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (sel_req == SEL_W'(p)) req_raw = pad_in[p];
      if (sel_pri == SEL_W'(p)) pri_raw = pad_in[p];
    end
  end

  // Output drive, one slice per pad.
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic hit_act;
    logic hit_ant;
    assign hit_act   = (sel_act == SEL_W'(p));
    assign hit_ant   = (sel_ant == SEL_W'(p));
    assign pad_oe[p] = !map_conflict && (hit_act || hit_ant);
    assign pad_out[p] = pad_oe[p] && (hit_act ? act_lvl : ant_lvl);
  end

endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter
  import coex_pkg::*;
#(
  parameter  int NUM_PADS    = 7,
  parameter  int SYNC_STAGES = 2,
  localparam int SEL_W       = $clog2(NUM_PADS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                three_wire,
  input  logic                wlan_busy,
  input  logic                wlan_hi_pri,
  input  logic                ant_force_en,
  input  logic                ant_force_val,
  input  logic [SEL_W-1:0]    sel_req,
  input  logic [SEL_W-1:0]    sel_pri,
  input  logic [SEL_W-1:0]    sel_act,
  input  logic [SEL_W-1:0]    sel_ant,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic                map_conflict
);

  logic req_raw, pri_raw;
  logic req_s, pri_s;
  logic req_rise, slot_active, bt_grant;
  logic act_lvl, ant_lvl;

  coex_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pri_raw, req_raw}),
    .q     ({pri_s, req_s})
  );

  coex_decider u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_s       (req_s),
    .pri_s       (pri_s),
    .three_wire  (three_wire),
    .wlan_busy   (wlan_busy),
    .wlan_hi_pri (wlan_hi_pri),
    .req_rise    (req_rise),
    .slot_active (slot_active),
    .bt_grant    (bt_grant)
  );

  assign act_lvl = coex_act_level(slot_active, bt_grant, wlan_busy);
  assign ant_lvl = coex_ant_level(slot_active, bt_grant, ant_force_en, ant_force_val);

  coex_padmux #(.NUM_PADS(NUM_PADS), .SEL_W(SEL_W)) u_mux (
    .three_wire   (three_wire),
    .sel_req      (sel_req),
    .sel_pri      (sel_pri),
    .sel_act      (sel_act),
    .sel_ant      (sel_ant),
    .pad_in       (pad_in),
    .act_lvl      (act_lvl),
    .ant_lvl      (ant_lvl),
    .req_raw      (req_raw),
    .pri_raw      (pri_raw),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .map_conflict (map_conflict)
  );

  AST_OUTSIDE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_active && !ant_force_en) |-> (act_lvl == wlan_busy) && !ant_lvl); // R6

  AST_SLOT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && !ant_force_en) |-> (act_lvl != ant_lvl)); // R7

  AST_OE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pad_oe) <= 2); // R8

  AST_CONFLICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    map_conflict |-> (pad_oe == '0)); // R9

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !slot_active); // R10

endmodule

// File: tb/sim_coex_arbiter.sv
`timescale 1ns/1ps
module sim_coex_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       three_wire = 1'b1, wlan_busy = 1'b0, wlan_hi_pri = 1'b0;
  logic       ant_force_en = 1'b0, ant_force_val = 1'b0;
  logic [2:0] sel_req = 3'd0, sel_pri = 3'd1, sel_act = 3'd2, sel_ant = 3'd3;
  logic [6:0] pad_in;
  logic [6:0] pad_out, pad_oe;
  logic       map_conflict;

  logic       bt_req = 1'b0, bt_pri = 1'b0;
  logic [6:0] noise = 7'd0;
  string      phase = "R10";
  int         compared = 0, mismatched = 0;
  bit         done = 1'b0;

  int rq[$] = '{0, 0, 0, 0};
  int pq[$] = '{0, 0, 0, 0};
  bit m_slot = 1'b0, m_grant = 1'b0;

  always #2.5 clk = ~clk;

  coex_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .three_wire(three_wire), .wlan_busy(wlan_busy),
    .wlan_hi_pri(wlan_hi_pri), .ant_force_en(ant_force_en), .ant_force_val(ant_force_val),
    .sel_req(sel_req), .sel_pri(sel_pri), .sel_act(sel_act), .sel_ant(sel_ant),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .map_conflict(map_conflict)
  );

  // Pads: background noise, overwritten by the Bluetooth-side levels on mapped pads.
  always @* begin
    pad_in = noise;
    if (sel_req < 3'd7) pad_in[sel_req] = bt_req;
    if (sel_pri < 3'd7) pad_in[sel_pri] = bt_pri;
  end

  function automatic bit pad_bit(input logic [2:0] s);
    return (s < 3'd7) ? pad_in[s] : 1'b0;
  endfunction

  // Reference model: history queues of sampled pad levels.
  always @(posedge clk) begin
    if (!rst_n) begin
      rq = '{0, 0, 0, 0};
      pq = '{0, 0, 0, 0};
      m_slot = 0;
      m_grant = 0;
    end else begin
      rq.push_front(int'(pad_bit(sel_req)));
      pq.push_front(int'(pad_bit(sel_pri)));
      void'(rq.pop_back());
      void'(pq.pop_back());
      if (rq[2] == 1 && rq[3] == 0)
        m_grant = !wlan_busy || (three_wire && pq[2] == 1 && !wlan_hi_pri);
      m_slot = (rq[2] == 1);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int cnt[8];
      bit e_conf, e_act, e_ant;
      logic [6:0] e_oe, e_out;
      foreach (cnt[i]) cnt[i] = 0;
      cnt[sel_req]++;
      if (three_wire) cnt[sel_pri]++;
      cnt[sel_act]++;
      cnt[sel_ant]++;
      e_conf = 0;
      for (int i = 0; i < 7; i++) if (cnt[i] > 1) e_conf = 1;
      e_act = m_slot ? !m_grant : wlan_busy;
      e_ant = ant_force_en ? ant_force_val : (m_slot && m_grant);
      e_oe = '0;
      e_out = '0;
      if (!e_conf) begin
        if (sel_act < 3'd7) begin e_oe[sel_act] = 1; e_out[sel_act] = e_act; end
        if (sel_ant < 3'd7) begin e_oe[sel_ant] = 1; e_out[sel_ant] = e_ant; end
      end
      compared++;
      if (pad_out !== e_out || pad_oe !== e_oe || map_conflict !== e_conf) begin
        mismatched++;
        $display("FAIL %s t=%0t actual out=%b oe=%b conf=%b expected out=%b oe=%b conf=%b",
                 phase, $time, pad_out, pad_oe, map_conflict, e_out, e_oe, e_conf);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic slot(input int hold);
    bt_req = 1'b1;
    cyc(hold);
    bt_req = 1'b0;
    cyc(6);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    phase = "R10"; cyc(3);
    phase = "R2"; wlan_busy = 0; slot(8);
    phase = "R1"; wlan_busy = 1; bt_pri = 0; slot(5);
    phase = "R3"; three_wire = 0; bt_pri = 1; wlan_busy = 1; slot(6);
    phase = "R4"; three_wire = 1; bt_pri = 1; wlan_hi_pri = 0; slot(6);
    wlan_hi_pri = 1; slot(6);
    bt_pri = 0; wlan_hi_pri = 0; slot(6);
    phase = "R5"; wlan_busy = 0; bt_req = 1; cyc(4); wlan_busy = 1; cyc(4);
    wlan_busy = 0; cyc(2); wlan_busy = 1; wlan_hi_pri = 1; cyc(3);
    bt_req = 0; wlan_hi_pri = 0; cyc(6);
    wlan_busy = 1; bt_req = 1; cyc(4); wlan_busy = 0; cyc(4); bt_req = 0; cyc(6);
    phase = "R6";
    for (int i = 0; i < 4; i++) begin wlan_busy = ~wlan_busy; cyc(2); end
    phase = "R7"; ant_force_en = 1; ant_force_val = 0; wlan_busy = 0; slot(6);
    ant_force_val = 1; cyc(4); ant_force_en = 0; cyc(2);
    phase = "R8"; sel_req = 3'd5; sel_pri = 3'd6; sel_act = 3'd0; sel_ant = 3'd7;
    noise = 7'b0011110; wlan_busy = 0; slot(6);
    wlan_busy = 1; slot(6);
    sel_ant = 3'd1; noise = 7'b0011100; wlan_busy = 0; slot(6);
    sel_req = 3'd7; noise = 7'h7F; bt_req = 1; cyc(8); bt_req = 0; cyc(4);
    noise = 7'd0;
    phase = "R9"; sel_req = 3'd0; sel_pri = 3'd1; sel_act = 3'd4; sel_ant = 3'd4; cyc(4);
    sel_ant = 3'd3; sel_pri = 3'd0; three_wire = 1; cyc(4);
    three_wire = 0; wlan_busy = 1; cyc(4);
    sel_pri = 3'd1; three_wire = 1; cyc(3);
    phase = "R10"; wlan_busy = 0; bt_req = 1; cyc(6);
    rst_n = 0; cyc(2); rst_n = 1; wlan_busy = 1; cyc(6);
    bt_req = 0; cyc(6);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule